// File: doc/BRIEF.md
# Hashed Page Translation Buffer with Range Invalidation

This block caches virtual-to-physical page translations in a direct-mapped array of 1024 slots. The slot for a virtual page number (VPN) comes from a hash of that number. A lookup returns a registered response one cycle later. The response carries a hit flag, the physical address (the stored frame number joined to the page offset of the request) and the stored attributes: address-space tag, permission bits, global bit and the slot's age.

The maintenance side offers four commands:
- Insert a translation.
- Invalidate one page, but only when its tag matches.
- Clear every slot.
- Invalidate every page touched by a half-open address range.

A small sequencer runs the full clear and the range walk. It raises `busy` while it runs and pulses `done` when it finishes. Lookups issued while `busy` is high report a miss.

Top module: `vpage_xlate_buf`

## Requirements
- R1: The slot index is VPN[9:0] XOR VPN[19:10]. Two VPNs with the same index share one slot, so inserting the second one displaces the first.
- R2: A lookup presented with `lk_valid` produces `rsp_valid` on the next cycle. It hits only if the indexed slot is valid and its stored VPN equals the requested VPN.
- R3: On a hit, `rsp_paddr` equals the stored PPN placed above the 12 offset bits of `lk_vaddr`, and `rsp_asid`, `rsp_perm` and `rsp_global` return the stored values. On a miss, all of these are zero.
- R4: On a hit, `rsp_age` shows the slot's age before the lookup, and the lookup clears that age to 0; on a miss `rsp_age` is 0. Every accepted lookup adds one to the age of every other slot, saturating at 15.
- R5: An insert writes the VPN, PPN and attributes into the indexed slot, marks the slot valid and sets its age to 0.
- R6: A single-page invalidate clears the indexed slot only when the stored VPN equals the requested VPN. A request with a different tag leaves the slot intact.
- R7: A full clear makes every slot invalid. `busy` is high for exactly one cycle, and `done` then pulses for one cycle.
- R8: A range command invalidates, as in R6, the page of each address start, start+4096, ..., as long as the address is below end. `busy` stays high for (page count + 1) cycles, then `done` pulses once. When start >= end, no page is touched.
- R9: While `busy` is high, lookups report a miss and leave all ages unchanged, and all maintenance commands are ignored.
- R10: Maintenance commands presented in the same cycle resolve by priority: full clear, then range, then single invalidate, then insert. The losing commands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_asid | output | 8 | Stored address-space tag |
| rsp_perm | output | 3 | Stored permission bits |
| rsp_global | output | 1 | Stored global bit |
| rsp_age | output | 4 | Age of the hit slot before the lookup |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | 20 | VPN to insert |
| ins_ppn | input | 20 | PPN to insert |
| ins_asid | input | 8 | Address-space tag to insert |
| ins_perm | input | 3 | Permission bits to insert |
| ins_global | input | 1 | Global bit to insert |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | VPN to invalidate |
| flush_valid | input | 1 | Full clear request |
| rng_valid | input | 1 | Range invalidate request |
| rng_start | input | 32 | First address of the range (inclusive) |
| rng_end | input | 32 | End address of the range (exclusive) |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that each lookup gets a response on the next cycle and that a lookup made while busy comes back as a miss. They also check that a hit carries the request's page offset and that `done` only follows a busy cycle and never overlaps one. Other behaviour shows up only in the bench's scenarios, because it depends on stored state across many cycles: slot eviction through the hash, tag-checked invalidation, age growth and saturation, the exact length of a range walk including an unaligned start and an empty range, and the command priority.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 10;
    localparam int ASID_W     = 8;
    localparam int PERM_W     = 3;
    localparam int AGE_W      = 4;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PPN_W      = PA_W - PAGE_SHIFT;
    localparam int ENTRIES    = 1 << IDX_W;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [PERM_W-1:0] perm;
        logic              glb;
        logic [AGE_W-1:0]  age;
    } slot_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RANGE,
        SEQ_FLUSH
    } seq_st_e;
endpackage

// File: rtl/xtlb_hash.sv
module xtlb_hash #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 10
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    generate
        if (VPN_W >= 2 * IDX_W) begin : g_fold
            assign idx = vpn[IDX_W-1:0] ^ vpn[2*IDX_W-1:IDX_W];
        end else begin : g_low
            assign idx = vpn[IDX_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/xtlb_rng_seq.sv
module xtlb_rng_seq
    import xtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_req,
    input  logic             rng_req,
    input  logic [VA_W-1:0]  rng_start,
    input  logic [VA_W-1:0]  rng_end,
    output logic             busy,
    output logic             done,
    output logic             clr_all,
    output logic             walk_inv,
    output logic [VPN_W-1:0] walk_vpn
);
    localparam logic [VA_W:0] PAGE_STEP = {{VA_W{1'b0}}, 1'b1} << PAGE_SHIFT;

    typedef struct packed {
        seq_st_e       st;
        logic [VA_W:0] cur;
        logic [VA_W:0] lim;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        clr_all  = 1'b0;
        walk_inv = 1'b0;
        walk_vpn = s_q.cur[VA_W-1:PAGE_SHIFT];
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (flush_req) begin
                    s_d.st = SEQ_FLUSH;
                end else if (rng_req) begin
                    s_d.st  = SEQ_RANGE;
                    s_d.cur = {1'b0, rng_start};
                    s_d.lim = {1'b0, rng_end};
                end
            end
            SEQ_FLUSH: begin
                clr_all  = 1'b1;
                s_d.st   = SEQ_IDLE;
                s_d.done = 1'b1;
            end
            SEQ_RANGE: begin
                if (s_q.cur < s_q.lim) begin
                    walk_inv = 1'b1;
                    s_d.cur  = s_q.cur + PAGE_STEP;
                end else begin
                    s_d.st   = SEQ_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, cur: '0, lim: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != SEQ_IDLE);
    assign done = s_q.done;

    // R8: completion pulse only directly after a busy cycle
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R8: done never overlaps busy
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

// File: rtl/vpage_xlate_buf.sv
module vpage_xlate_buf
    import xtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [ASID_W-1:0] rsp_asid,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_global,
    output logic [AGE_W-1:0]  rsp_age,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [PERM_W-1:0] ins_perm,
    input  logic              ins_global,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush_valid,
    input  logic              rng_valid,
    input  logic [VA_W-1:0]   rng_start,
    input  logic [VA_W-1:0]   rng_end,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [PA_W-1:0]   paddr;
        logic [ASID_W-1:0] asid;
        logic [PERM_W-1:0] perm;
        logic              glb;
        logic [AGE_W-1:0]  age;
    } rsp_t;

    slot_t              ent_d [ENTRIES];
    slot_t              ent_q [ENTRIES];
    logic [ENTRIES-1:0] val_d, val_q;
    rsp_t               rsp_d, rsp_q;

    logic             clr_all, walk_inv;
    logic [VPN_W-1:0] walk_vpn, kill_vpn;
    logic [IDX_W-1:0] lk_idx, kill_idx, ins_idx;
    logic [VPN_W-1:0] lk_vpn;

    assign lk_vpn   = lk_vaddr[VA_W-1:PAGE_SHIFT];
    assign kill_vpn = walk_inv ? walk_vpn : inv_vpn;

    xtlb_rng_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_req(flush_valid),
        .rng_req  (rng_valid),
        .rng_start(rng_start),
        .rng_end  (rng_end),
        .busy     (busy),
        .done     (done),
        .clr_all  (clr_all),
        .walk_inv (walk_inv),
        .walk_vpn (walk_vpn)
    );

    xtlb_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash_lk  (.vpn(lk_vpn),   .idx(lk_idx));
    xtlb_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash_inv (.vpn(kill_vpn), .idx(kill_idx));
    xtlb_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash_ins (.vpn(ins_vpn),  .idx(ins_idx));

    logic lk_go, lk_hit, cmd_free, inv_go, ins_go;
    assign lk_go    = lk_valid && !busy;
    assign lk_hit   = lk_go && val_q[lk_idx] && (ent_q[lk_idx].vpn == lk_vpn);
    // R10: clear and range outrank single invalidate, which outranks insert
    assign cmd_free = !busy && !flush_valid && !rng_valid;
    assign inv_go   = cmd_free && inv_valid;
    assign ins_go   = cmd_free && !inv_valid && ins_valid;

    always_comb begin
        ent_d = ent_q;
        val_d = val_q;
        rsp_d = '0;

        rsp_d.vld = lk_valid;
        if (lk_hit) begin
            rsp_d.hit   = 1'b1;
            rsp_d.paddr = {ent_q[lk_idx].ppn, lk_vaddr[PAGE_SHIFT-1:0]};
            rsp_d.asid  = ent_q[lk_idx].asid;
            rsp_d.perm  = ent_q[lk_idx].perm;
            rsp_d.glb   = ent_q[lk_idx].glb;
            rsp_d.age   = ent_q[lk_idx].age;
        end

        if (lk_go) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (lk_hit && (lk_idx == IDX_W'(i))) begin
                    ent_d[i].age = '0;
                end else if (ent_q[i].age != '1) begin
                    ent_d[i].age = ent_q[i].age + 1'b1;
                end
            end
        end

        if ((walk_inv || inv_go) && (ent_q[kill_idx].vpn == kill_vpn)) begin
            val_d[kill_idx] = 1'b0;
        end

        if (ins_go) begin
            ent_d[ins_idx] = '{vpn: ins_vpn, ppn: ins_ppn, asid: ins_asid,
                               perm: ins_perm, glb: ins_global, age: '0};
            val_d[ins_idx] = 1'b1;
        end

        if (clr_all) begin
            val_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            rsp_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            val_q <= val_d;
            rsp_q <= rsp_d;
            ent_q <= ent_d;
        end
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_asid   = rsp_q.asid;
    assign rsp_perm   = rsp_q.perm;
    assign rsp_global = rsp_q.glb;
    assign rsp_age    = rsp_q.age;

    // R2: every lookup is answered on the following cycle
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R9: lookups during a sequencer run come back as misses
    assert_busy_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && busy) |=> (rsp_valid && !rsp_hit));
    // R3: a hit keeps the request's page offset
    assert_hit_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0])));
endmodule

// File: tb/tb_vpage_xlate_buf.sv
module tb_vpage_xlate_buf;
    localparam int CLK_PERIOD = 10;
    localparam int N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_global, busy, done;
    logic [31:0] rsp_paddr;
    logic [7:0]  rsp_asid;
    logic [2:0]  rsp_perm;
    logic [3:0]  rsp_age;
    logic        ins_valid = 1'b0;
    logic [19:0] ins_vpn = '0, ins_ppn = '0;
    logic [7:0]  ins_asid = '0;
    logic [2:0]  ins_perm = '0;
    logic        ins_global = 1'b0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_valid = 1'b0, rng_valid = 1'b0;
    logic [31:0] rng_start = '0, rng_end = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpage_xlate_buf dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_asid(rsp_asid), .rsp_perm(rsp_perm), .rsp_global(rsp_global),
        .rsp_age(rsp_age), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
        .ins_ppn(ins_ppn), .ins_asid(ins_asid), .ins_perm(ins_perm),
        .ins_global(ins_global), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush_valid(flush_valid), .rng_valid(rng_valid), .rng_start(rng_start),
        .rng_end(rng_end), .busy(busy), .done(done)
    );

    // reference model, built from the requirements
    logic        m_val  [N];
    logic [19:0] m_vpn  [N];
    logic [19:0] m_ppn  [N];
    logic [7:0]  m_asid [N];
    logic [2:0]  m_perm [N];
    logic        m_glb  [N];
    logic [3:0]  m_age  [N];
    logic [19:0] pool   [24];

    function automatic int f_idx(input logic [19:0] v);
        return int'(v[9:0] ^ v[19:10]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_valid = 0; ins_valid = 0; inv_valid = 0; flush_valid = 0; rng_valid = 0;
    endtask

    task automatic m_inv(input logic [19:0] v);
        int k = f_idx(v);
        if (m_vpn[k] == v) m_val[k] = 1'b0;
    endtask

    task automatic do_lookup(input logic [19:0] v, input logic [11:0] off, input string req);
        int k = f_idx(v);
        bit  eh = m_val[k] && (m_vpn[k] == v);
        logic [31:0] ep = eh ? {m_ppn[k], off} : 32'h0;
        logic [3:0]  ea = eh ? m_age[k] : 4'h0;
        logic [11:0] eattr = eh ? {m_asid[k], m_perm[k], m_glb[k]} : 12'h0;
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {v, off};
        @(posedge clk); #1;
        clear_inputs();
        for (int i = 0; i < N; i++) begin
            if (eh && i == k) m_age[i] = 0;
            else if (m_age[i] != 4'hf) m_age[i] = m_age[i] + 1;
        end
        chk(rsp_valid == 1'b1, {req, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_hit == eh, {req, " R2 hit"}, 64'(rsp_hit), 64'(eh));
        chk(rsp_paddr == ep, {req, " R3 paddr"}, 64'(rsp_paddr), 64'(ep));
        chk({rsp_asid, rsp_perm, rsp_global} == eattr, {req, " R3 attrs"},
            64'({rsp_asid, rsp_perm, rsp_global}), 64'(eattr));
        chk(rsp_age == ea, {req, " R4 age"}, 64'(rsp_age), 64'(ea));
    endtask

    task automatic m_insert(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a,
                            input logic [2:0] pm, input logic g);
        int k = f_idx(v);
        m_val[k] = 1; m_vpn[k] = v; m_ppn[k] = p; m_asid[k] = a;
        m_perm[k] = pm; m_glb[k] = g; m_age[k] = 0;
    endtask

    task automatic do_insert(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a,
                             input logic [2:0] pm, input logic g);
        @(negedge clk);
        ins_valid = 1; ins_vpn = v; ins_ppn = p; ins_asid = a; ins_perm = pm; ins_global = g;
        @(posedge clk); #1;
        clear_inputs();
        m_insert(v, p, a, pm, g);
    endtask

    task automatic do_inv(input logic [19:0] v);
        @(negedge clk);
        inv_valid = 1; inv_vpn = v;
        @(posedge clk); #1;
        clear_inputs();
        m_inv(v);
    endtask

    // inputs already driven in this low phase; count busy cycles and check done
    task automatic finish_maint(input int exp_cnt, input string req);
        int cnt = 0;
        int guard = 0;
        @(posedge clk); #1;
        clear_inputs();
        while (busy && guard < 5000) begin
            cnt++; guard++;
            @(posedge clk); #1;
        end
        chk(cnt == exp_cnt, {req, " busy cycles"}, 64'(cnt), 64'(exp_cnt));
        chk(done == 1'b1, {req, " done pulse"}, 64'(done), 64'd1);
        @(posedge clk); #1;
        chk(done == 1'b0, {req, " done single cycle"}, 64'(done), 64'd0);
    endtask

    task automatic do_range(input logic [31:0] s, input logic [31:0] e, input string req);
        int pages = 0;
        @(negedge clk);
        rng_valid = 1; rng_start = s; rng_end = e;
        for (logic [32:0] a = {1'b0, s}; a < {1'b0, e}; a = a + 33'h1000) begin
            m_inv(a[31:12]);
            pages++;
        end
        finish_maint(pages + 1, req);
    endtask

    task automatic m_flush();
        for (int i = 0; i < N; i++) m_val[i] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0;
            m_perm[i] = 0; m_glb[i] = 0; m_age[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        chk(busy == 0 && done == 0 && rsp_valid == 0, "reset R2 outputs idle",
            64'({busy, done, rsp_valid}), 64'd0);
        do_lookup(20'h12345, 12'h010, "reset R2 empty miss");

        // R1: 0x00001 and 0x00400 both index slot 1
        do_insert(20'h00001, 20'hAAAAA, 8'h11, 3'b101, 1'b1);
        do_lookup(20'h00001, 12'h123, "R1 first resident");
        do_insert(20'h00400, 20'hBBBBB, 8'h22, 3'b011, 1'b0);
        do_lookup(20'h00001, 12'h123, "R1 displaced");
        do_lookup(20'h00400, 12'hFFF, "R3 paddr offset all ones");
        do_lookup(20'h00400, 12'h000, "R4 age cleared on hit");

        // R6: tag-mismatched invalidate keeps the slot
        do_inv(20'h00001);
        do_lookup(20'h00400, 12'h456, "R6 mismatch keeps slot");
        do_inv(20'h00400);
        do_lookup(20'h00400, 12'h456, "R6 matched invalidate");

        // R4: saturation after many unrelated lookups
        do_insert(20'hCAFE0, 20'h0BEEF, 8'h33, 3'b111, 1'b0);
        for (int i = 0; i < 20; i++) do_lookup(20'h00777, 12'h0, "R4 unrelated miss");
        do_lookup(20'hCAFE0, 12'h042, "R4 saturated age");

        // R8: unaligned start, three pages
        do_insert(20'h4FFFF, 20'h00001, 8'h1, 3'b1, 1'b0);
        do_insert(20'h50000, 20'h00002, 8'h2, 3'b1, 1'b0);
        do_insert(20'h50001, 20'h00003, 8'h3, 3'b1, 1'b0);
        do_insert(20'h50002, 20'h00004, 8'h4, 3'b1, 1'b0);
        do_insert(20'h50003, 20'h00005, 8'h5, 3'b1, 1'b0);
        do_range(32'h5000_0800, 32'h5000_3000, "R8 range walk");
        for (int i = 0; i < 5; i++) do_lookup(20'h4FFFF + 20'(i), 12'h8, "R8 range result");
        do_range(32'h5000_4000, 32'h5000_4000, "R8 empty range");
        do_lookup(20'h50003, 12'h8, "R8 empty range kept entry");

        // R9: lookup and insert while busy
        @(negedge clk);
        rng_valid = 1; rng_start = 32'h7000_0000; rng_end = 32'h7002_8000;
        @(posedge clk); #1;
        clear_inputs();
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {20'h50003, 12'h0};
        ins_valid = 1; ins_vpn = 20'h13579; ins_ppn = 20'h1; ins_asid = 0; ins_perm = 0; ins_global = 0;
        @(posedge clk); #1;
        clear_inputs();
        chk(rsp_valid && !rsp_hit && rsp_age == 0, "R9 busy lookup miss",
            64'({rsp_valid, rsp_hit}), 64'h2);
        begin
            int guard = 0;
            while (!done && guard < 5000) begin guard++; @(posedge clk); #1; end
        end
        for (logic [32:0] a = 33'h0_7000_0000; a < 33'h0_7002_8000; a = a + 33'h1000) m_inv(a[31:12]);
        do_lookup(20'h13579, 12'h0, "R9 insert ignored while busy");
        do_lookup(20'h50003, 12'h0, "R9 entry untouched by busy lookup");

        // R10: clear beats insert
        @(negedge clk);
        flush_valid = 1; ins_valid = 1; ins_vpn = 20'h24680; ins_ppn = 20'h9;
        m_flush();
        finish_maint(1, "R7 R10 flush over insert");
        do_lookup(20'h24680, 12'h0, "R10 insert lost to clear");
        do_lookup(20'hCAFE0, 12'h0, "R7 cleared");
        // R10: invalidate beats insert
        do_insert(20'h11111, 20'h7, 8'h7, 3'b1, 1'b1);
        @(negedge clk);
        inv_valid = 1; inv_vpn = 20'h11111; ins_valid = 1; ins_vpn = 20'h22222; ins_ppn = 20'h8;
        @(posedge clk); #1;
        clear_inputs();
        m_inv(20'h11111);
        do_lookup(20'h22222, 12'h0, "R10 insert lost to invalidate");
        do_lookup(20'h11111, 12'h0, "R10 invalidate applied");
        // R10: clear beats range
        @(negedge clk);
        flush_valid = 1; rng_valid = 1; rng_start = 32'h0; rng_end = 32'h0010_0000;
        m_flush();
        finish_maint(1, "R10 flush over range");

        // random phase, pool built to collide in the hash
        for (int i = 0; i < 24; i++) begin
            logic [9:0] hi = 10'($urandom);
            pool[i] = {hi, hi ^ 10'(i % 12)};
        end
        for (int n = 0; n < 500; n++) begin
            int r = int'($urandom % 10);
            logic [19:0] v = pool[$urandom % 24];
            if (r < 6) do_lookup(v, 12'($urandom), "R2 R3 R4 random lookup");
            else if (r < 9) do_insert(v, 20'($urandom), 8'($urandom), 3'($urandom), 1'($urandom));
            else do_inv(v);
        end
        do_range({pool[3], 12'h0}, {pool[3], 12'h0} + 32'h3000, "R8 random range");
        for (int i = 0; i < 24; i++) do_lookup(pool[i], 12'h5, "R5 R6 final sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule